// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a clocked static memory with a 32-bit data path split into four 8-bit lanes, with its depth set by a parameter. Every control input is sampled on the rising clock edge. An access begins when one of two address strobes latches an external address. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, chosen by that cycle's write inputs. After the start, a 2-bit burst counter steps through the two low address bits in linear order and wraps after four beats. The upper address bits stay fixed for the whole burst.

Three chip selects gate the two strobes, and the processor-side strobe is gated more strictly than the controller-side one. The chip selects do not gate continue cycles (advance low) or suspend cycles (advance high, address held), so a burst that has started runs on even when the primary select goes inactive. The write decode has a global write that stores all four bytes. Below it is a byte-write enable that lets four per-lane enables pick single bytes. Read data is registered and comes with a valid flag. A simple output-enable gate forces the data bus to zero.

Top module: `sync_burst_sram`

## Requirements
- R1: A deselect cycle occurs when the primary select `cs_n` is high and `ads_c_n` is low. It also occurs when `cs_n` is low, either strobe is low, and a secondary select is inactive (`cs_hi` low or `cs_lo_n` high). A deselect ends any burst, and on the next clock `rd_valid` is 0 and `rd_data` is zero.
- R2: With all three selects active, `ads_p_n` low starts a burst read at `addr`. All write inputs are ignored in that cycle, and memory is left unchanged.
- R3: While `cs_n` is high, `ads_p_n` is ignored. The cycle is then decoded as if `ads_p_n` were high.
- R4: When `ads_c_n` is low, `ads_p_n` is high and all selects are active, a burst starts at `addr`. The cycle's write decode chooses between a read and a write.
- R5: When both strobes are low and all selects are active, the cycle is a read, whatever the write inputs are.
- R6: When both strobes are high and `adv_n` is low during an active burst, the next address is accessed. The next address keeps the upper bits and sets the low two bits to (previous + 1) mod 4. This holds at any level of `cs_n`.
- R7: When both strobes are high and `adv_n` is high during an active burst, the current address is accessed again and the burst position does not move.
- R8: `gw_n` low writes all four bytes of the accessed word, whatever `bwe_n` and `bw_n` are.
- R9: When `gw_n` is high, `bwe_n` high gives a read. When `gw_n` is high and `bwe_n` is low, lane i (bits 8i+7:8i) is written only where `bw_n[i]` is low. If no bit of `bw_n` is low, the cycle is a read. A write cycle gives `rd_valid` 0 on the next clock.
- R10: A read cycle presents the accessed word on `rd_data` with `rd_valid` 1 one clock after the edge that accepted it.
- R11: `oe_n` high forces `rd_data` to zero and leaves `rd_valid` unchanged.
- R12: A continue or suspend cycle when no burst is active leaves memory unchanged and gives `rd_valid` 0 on the next clock.
- R13: After reset, `rd_valid` is 0, `rd_data` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| ads_p_n | input | 1 | Processor-side address strobe, active low |
| ads_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable gate, active low |
| addr | input | AW | External word address, AW = clog2(DEPTH) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, zero when gated or not valid |
| rd_valid | output | 1 | Read data valid |

## Verification
A burst counter that drifts, wraps to the wrong value, or keeps running after a deselect reads from the wrong word. The mismatch shows on `rd_data` one clock after the faulty beat. A broken priority or gating decode appears the same way: it either writes when it should read, or it raises `rd_valid` after a deselect or an idle continue. A missed write appears only later, when the bench reads that word back, and a wrong byte mask corrupts only the affected lanes. So the bench reads back every location it touches with bursts that cross the wrap point, and it compares every cycle against its own model of the array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             ads_p_n,
  input  logic             ads_c_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output cyc_e             cyc,
  output logic [LANES-1:0] wr_mask
);
  logic             sec_ok;
  logic [LANES-1:0] wdec;

  always_comb begin
    sec_ok = cs_hi & ~cs_lo_n;
    if (!gw_n)       wdec = '1;
    else if (!bwe_n) wdec = ~bw_n;
    else             wdec = '0;

    cyc     = CYC_IDLE;
    wr_mask = '0;
    if (cs_n && !ads_c_n) begin
      cyc = CYC_DESEL;
    end else if (!cs_n && (!ads_p_n || !ads_c_n) && !sec_ok) begin
      cyc = CYC_DESEL;
    end else if (!cs_n && !ads_p_n) begin
      cyc = CYC_START;           // processor strobe: always a read
    end else if (!ads_c_n) begin
      cyc     = CYC_START;
      wr_mask = wdec;
    end else if (!adv_n) begin
      cyc     = CYC_CONT;
      wr_mask = wdec;
    end else begin
      cyc     = CYC_SUSP;
      wr_mask = wdec;
    end
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          cyc,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic          acc_en,
  output logic          active
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    cnt_q;

  always_comb begin
    acc_addr = {hi_q, cnt_q};
    acc_en   = 1'b0;
    case (cyc)
      CYC_START: begin acc_addr = ext_addr;                  acc_en = 1'b1;   end
      CYC_CONT:  begin acc_addr = {hi_q, cnt_q + 2'd1};     acc_en = active; end
      CYC_SUSP:  begin acc_addr = {hi_q, cnt_q};            acc_en = active; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hi_q   <= '0;
      cnt_q  <= '0;
    end else begin
      case (cyc)
        CYC_DESEL: active <= 1'b0;
        CYC_START: begin
          active <= 1'b1;
          hi_q   <= ext_addr[AW-1:2];
          cnt_q  <= ext_addr[1:0];
        end
        CYC_CONT: if (active) cnt_q <= cnt_q + 2'd1;
        default: ;
      endcase
    end
  end

  // R7: suspend keeps the burst position
  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_SUSP && active) |=> ($stable(cnt_q) && $stable(hi_q) && active));
  // R1: deselect ends the burst
  a_r1_desel_ends_burst: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_DESEL) |=> !active);
  // R6: continue never moves the upper address bits
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CONT && active) |=> (hi_q == $past(hi_q)));
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             ads_p_n,
  input  logic             ads_c_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  cyc_e             cyc;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    acc_addr;
  logic             acc_en;
  logic             active;
  logic             is_read;
  logic [DW-1:0]    ram_q;

  sbs_cycle_decode #(.LANES(LANES)) dec_i (
    .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .cyc(cyc), .wr_mask(wr_mask)
  );

  sbs_burst_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst(rst), .cyc(cyc), .ext_addr(addr),
    .acc_addr(acc_addr), .acc_en(acc_en), .active(active)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_ram #(.DEPTH(DEPTH), .W(LANE_W), .AW(AW)) ram_i (
      .clk(clk),
      .we(acc_en & wr_mask[g]),
      .addr(acc_addr),
      .wd(wr_data[g*LANE_W +: LANE_W]),
      .rd(ram_q[g*LANE_W +: LANE_W])
    );
  end

  assign is_read = acc_en & ~(|wr_mask);

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= is_read;
  end

  assign rd_data = (rd_valid && !oe_n) ? ram_q : '0;

  // R1: a deselect gives no valid data next clock
  a_r1_desel_invalid: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_DESEL) |=> !rd_valid);
  // R12: continue/suspend without a burst is inert
  a_r12_idle_inert: assert property (@(posedge clk) disable iff (rst)
    ((cyc == CYC_CONT || cyc == CYC_SUSP) && !active) |=> !rd_valid);
  // R9: a write cycle yields no valid read data
  a_r9_write_not_valid: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (|wr_mask)) |=> !rd_valid);
  // R2: processor strobe with all selects never writes
  a_r2_strobe_reads: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs_hi && !cs_lo_n && !ads_p_n) |-> (wr_mask == '0));
  // R8: global write asserts every lane during an access other than a processor start
  a_r8_global_all: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !gw_n && !(!cs_n && !ads_p_n)) |-> (&wr_mask));
  // R10: valid data only follows an accepted read
  a_r10_valid_origin: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_en));
endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, cs_hi, cs_lo_n, ads_p_n, ads_c_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0]  bw_n;
  logic [AW-1:0] addr;
  logic [31:0] wr_data, rd_data;
  logic        rd_valid;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0]   ref_mem [DEPTH];
  logic          m_act;
  logic [AW-3:0] m_hi;
  logic [1:0]    m_cnt;

  always #4 clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .ads_p_n(ads_p_n), .ads_c_n(ads_c_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] got_d, input logic got_v,
                       input logic [31:0] exp_d, input logic exp_v);
    n_tests++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got data=%h valid=%b, expected data=%h valid=%b",
               tag, got_d, got_v, exp_d, exp_v);
    end
  endtask

  // one clock: model the cycle, clock it, compare on the falling edge
  task automatic step(input string tag);
    int       kind;       // 0 none, 1 desel, 2 start, 3 cont, 4 susp
    logic     forced_rd, en, ev;
    logic [3:0]  mask;
    logic [AW-1:0] a;
    logic [31:0] ed;
    forced_rd = 1'b0;
    if (cs_n && !ads_c_n) kind = 1;
    else if (!cs_n && (!ads_p_n || !ads_c_n) && !(cs_hi && !cs_lo_n)) kind = 1;
    else if (!cs_n && !ads_p_n) begin kind = 2; forced_rd = 1'b1; end
    else if (!ads_c_n) kind = 2;
    else if (!adv_n) kind = 3;
    else kind = 4;
    if (!gw_n) mask = 4'hF; else if (!bwe_n) mask = ~bw_n; else mask = 4'h0;
    if (forced_rd) mask = 4'h0;
    en = 1'b0; a = '0;
    case (kind)
      2: begin en = 1'b1; a = addr; end
      3: begin en = m_act; a = {m_hi, m_cnt + 2'd1}; end
      4: begin en = m_act; a = {m_hi, m_cnt}; end
      default: ;
    endcase
    ev = en && (mask == 4'h0);
    ed = ref_mem[a];
    if (en) for (int i = 0; i < 4; i++)
      if (mask[i]) ref_mem[a][i*8 +: 8] = wr_data[i*8 +: 8];
    case (kind)
      1: m_act = 1'b0;
      2: begin m_act = 1'b1; m_hi = addr[AW-1:2]; m_cnt = addr[1:0]; end
      3: if (m_act) m_cnt = m_cnt + 2'd1;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, rd_valid, (ev && !oe_n) ? ed : 32'h0, ev);
  endtask

  task automatic idle_in();
    cs_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; ads_p_n = 1'b1; ads_c_n = 1'b1;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF; oe_n = 1'b0;
  endtask

  task automatic start_p(input logic [AW-1:0] a, input string tag);
    idle_in(); ads_p_n = 1'b0; addr = a; step(tag);
  endtask
  task automatic start_c(input logic [AW-1:0] a, input logic g, input string tag);
    idle_in(); ads_c_n = 1'b0; gw_n = g; addr = a; step(tag);
  endtask
  task automatic cont(input string tag);
    idle_in(); adv_n = 1'b0; step(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle_in(); addr = '0; wr_data = '0; rst = 1'b1;
    m_act = 1'b0; m_hi = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset", rd_data, rd_valid, 32'h0, 1'b0);
    rst = 1'b0;

    // R8 + R6: fill memory with global-write bursts of four beats
    for (int b = 0; b < DEPTH / 4; b++) begin
      wr_data = $urandom; start_c(AW'(b * 4), 1'b0, "R8 fill start");
      for (int k = 0; k < 3; k++) begin
        idle_in(); adv_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'h5;
        wr_data = $urandom; step("R8 fill continue");
      end
    end

    // R10/R6: read burst from 5 wraps 6,7,4; R7 suspend
    start_p(AW'(5), "R10 read start");
    cont("R6 next"); cont("R6 next");
    cont("R6 wrap");
    idle_in(); step("R7 suspend");
    cont("R6 after suspend");

    // R2: processor strobe with global write low reads; memory unchanged
    idle_in(); ads_p_n = 1'b0; gw_n = 1'b0; wr_data = 32'hDEADBEEF; addr = AW'(9);
    step("R2 write ignored");
    start_p(AW'(9), "R2 readback");

    // R5: both strobes low => read
    idle_in(); ads_p_n = 1'b0; ads_c_n = 1'b0; gw_n = 1'b0; addr = AW'(12);
    wr_data = 32'h12345678; step("R5 priority");
    start_p(AW'(12), "R5 readback");

    // R4: controller strobe write with byte mask, then read
    idle_in(); ads_c_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010; addr = AW'(20);
    wr_data = 32'hA1B2C3D4; step("R9 byte write start");
    start_c(AW'(20), 1'b1, "R4 read start");
    // R9: bwe low, no lanes => read
    idle_in(); adv_n = 1'b0; bwe_n = 1'b0; bw_n = 4'hF; wr_data = 32'hFFFFFFFF;
    step("R9 no lane read");
    idle_in(); adv_n = 1'b0; bwe_n = 1'b1; bw_n = 4'h0; step("R9 bwe high read");

    // R3: primary select high, processor strobe ignored, continue runs (R6)
    idle_in(); cs_n = 1'b1; ads_p_n = 1'b0; adv_n = 1'b0; addr = AW'(40);
    step("R3 strobe ignored");
    idle_in(); cs_n = 1'b1; adv_n = 1'b1; step("R7 suspend cs high");

    // R11: output gate
    idle_in(); oe_n = 1'b1; adv_n = 1'b0; step("R11 oe gate");

    // R1: both deselect forms, then R12 inert continue/suspend
    idle_in(); cs_n = 1'b1; ads_c_n = 1'b0; step("R1 desel primary");
    idle_in(); adv_n = 1'b0; gw_n = 1'b0; wr_data = 32'h0BADF00D; step("R12 idle continue");
    idle_in(); gw_n = 1'b0; step("R12 idle suspend");
    start_p(AW'(33), "R12 readback");
    idle_in(); ads_p_n = 1'b0; cs_lo_n = 1'b1; step("R1 desel secondary");
    idle_in(); ads_c_n = 1'b0; cs_hi = 1'b0; step("R1 desel secondary hi");
    cont("R12 after desel");
    start_p(AW'(33), "R12 readback 2");
    for (int k = 0; k < 4; k++) cont("R6 readback wrap");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cs_n    = ($urandom_range(0, 9) == 0);
      cs_hi   = ($urandom_range(0, 9) != 0);
      cs_lo_n = ($urandom_range(0, 9) == 0);
      ads_p_n = !(r < 10);
      ads_c_n = !(r >= 10 && r < 25);
      adv_n   = ($urandom_range(0, 3) == 0);
      gw_n    = ($urandom_range(0, 5) != 0);
      bwe_n   = $urandom_range(0, 1);
      bw_n    = 4'($urandom);
      oe_n    = ($urandom_range(0, 7) == 0);
      addr    = AW'($urandom);
      wr_data = $urandom;
      step("R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule